// File: doc/BRIEF.md
# Scanline and Frame Interrupt Sequencer

This block turns the system clock into video timing events. A cycle divider counts clock cycles up to a programmable number of cycles per scanline and emits one line strobe per scanline. A line sequencer counts those strobes into a frame, signals the first line of vertical blanking and raises a frame interrupt pulse when the last line of a frame completes. An audio ticker counts the same line strobes and emits a strobe every 32 lines.

Two video standards are built in: a 60 Hz standard with 263 lines per frame and blanking from line 240, and a 50 Hz standard with 313 lines per frame and blanking from line 256. The integrator sets the cycles-per-line input to the system clock rate divided by the product of frame rate and lines per frame. The audio count runs straight across frame boundaries, so the audio tick has no fixed phase relation to the frame.

Top module: `scan_frame_seq`

## Requirements
- R1: While `rst` is high at a clock edge, all four strobes are low and `line_num` is 0 at the following clock; the standard is taken from `std_sel` during reset.
- R2: `line_stb` is a single-cycle pulse. Counting the first rising edge with `rst` low as edge 1, it first appears after edge `cycles_per_line`, then every `cycles_per_line` cycles. `cycles_per_line` must be at least 2.
- R3: `line_num` steps up by one in the same cycle as each `line_stb`, except on a frame end, and holds between strobes.
- R4: With `std_sel` = 0 (60 Hz), a frame has 263 lines and blanking starts when `line_num` reaches 240.
- R5: With `std_sel` = 1 (50 Hz), a frame has 313 lines and blanking starts when `line_num` reaches 256.
- R6: `vblank_stb` is high for exactly the cycle of the `line_stb` that brings `line_num` to the blanking start value of the active standard.
- R7: On the `line_stb` that completes the last line of a frame, `line_num` becomes 0 and `frame_irq` is high for that one cycle.
- R8: `audio_stb` is high on every 32nd `line_stb` counted since reset; the frame end does not restart this count.
- R9: `std_sel` is sampled only in reset and on the `frame_irq` cycle; a change inside a frame first alters the frame that follows.
- R10: `vblank_stb`, `frame_irq` and `audio_stb` are never high in a cycle where `line_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| std_sel | input | 1 | Video standard: 0 = 60 Hz / 263 lines, 1 = 50 Hz / 313 lines |
| cycles_per_line | input | CYC_W | Clock cycles per scanline (at least 2) |
| line_stb | output | 1 | One-cycle pulse at the end of each scanline |
| vblank_stb | output | 1 | One-cycle pulse when vertical blanking begins |
| frame_irq | output | 1 | One-cycle frame interrupt pulse at frame end |
| audio_stb | output | 1 | One-cycle pulse every 32 scanlines |
| line_num | output | LINE_W | Current scanline number within the frame |

## Verification
The audio tick shares its line strobe with both the blanking start and the frame end, so it can land in the same cycle as either. Under the 50 Hz standard, line 256 of the first frame is also the eighth audio period, so blanking and audio strobes coincide; after 32 whole frames of either standard the frame interrupt and the audio tick fall on the same strobe (line 8416 at 60 Hz, line 10016 at 50 Hz). The bench drives to those strobe counts and expects every coinciding pulse to be present together, with `line_num` at 256 and at 0 respectively.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic {STD_60 = 1'b0, STD_50 = 1'b1} vstd_e;

  localparam int LINES_60 = 263;
  localparam int VBL_60   = 240;
  localparam int LINES_50 = 313;
  localparam int VBL_50   = 256;
endpackage

// File: rtl/sfs_line_div.sv
module sfs_line_div #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CYC_W-1:0] cpl,
  output logic             wrap,
  output logic             line_stb
);
  logic [CYC_W-1:0] cyc;

  // Compare with >= so a shortened line length takes effect at once.
  assign wrap = (cyc >= cpl - CYC_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc      <= '0;
      line_stb <= 1'b0;
    end else begin
      line_stb <= wrap;
      cyc      <= wrap ? '0 : cyc + CYC_W'(1);
    end
  end

  // R2: the cycle counter restarts after each line end
  assert_cyc_restart_R2: assert property (@(posedge clk) disable iff (rst)
    line_stb |-> (cyc == '0));
endmodule

// File: rtl/sfs_line_seq.sv
module sfs_line_seq
  import sfs_pkg::*;
#(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap,
  input  logic              std_sel,
  output logic [LINE_W-1:0] line_num,
  output logic              vblank_stb,
  output logic              frame_irq
);
  localparam logic [LINE_W-1:0] TOT_A = LINE_W'(LINES_60);
  localparam logic [LINE_W-1:0] VBL_A = LINE_W'(VBL_60);
  localparam logic [LINE_W-1:0] TOT_B = LINE_W'(LINES_50);
  localparam logic [LINE_W-1:0] VBL_B = LINE_W'(VBL_50);

  vstd_e             std_q;
  logic [LINE_W-1:0] total, vbl_at, nxt;
  logic              frame_end;

  assign total     = (std_q == STD_50) ? TOT_B : TOT_A;
  assign vbl_at    = (std_q == STD_50) ? VBL_B : VBL_A;
  assign nxt       = line_num + LINE_W'(1);
  assign frame_end = wrap && (nxt == total);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_num   <= '0;
      vblank_stb <= 1'b0;
      frame_irq  <= 1'b0;
      std_q      <= vstd_e'(std_sel);
    end else begin
      vblank_stb <= wrap && !frame_end && (nxt == vbl_at);
      frame_irq  <= frame_end;
      if (wrap) line_num <= frame_end ? '0 : nxt;
      if (frame_end) std_q <= vstd_e'(std_sel);
    end
  end

  assert_frame_zero_R7: assert property (@(posedge clk) disable iff (rst)
    frame_irq |-> (line_num == '0));

  assert_vbl_line_R6: assert property (@(posedge clk) disable iff (rst)
    vblank_stb |-> (line_num == vbl_at));

  assert_line_range_R3: assert property (@(posedge clk) disable iff (rst)
    line_num < total);

  assert_line_step_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(wrap) && !frame_irq) |-> (line_num == LINE_W'($past(line_num) + LINE_W'(1))));
endmodule

// File: rtl/sfs_audio_tick.sv
module sfs_audio_tick #(
  parameter int AUDIO_LINES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  output logic audio_stb
);
  localparam int ACC_W = (AUDIO_LINES > 2) ? $clog2(AUDIO_LINES) : 1;
  localparam logic [ACC_W-1:0] LAST = ACC_W'(AUDIO_LINES - 1);

  logic [ACC_W-1:0] acc;
  logic             at_last;

  generate
    if ((AUDIO_LINES & (AUDIO_LINES - 1)) == 0) begin : g_pow2
      // Power of two: let the accumulator roll over on its own.
      assign at_last = &acc;
      always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (wrap) acc <= acc + ACC_W'(1);
      end
    end else begin : g_cmp
      assign at_last = (acc == LAST);
      always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (wrap) acc <= at_last ? '0 : acc + ACC_W'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) audio_stb <= 1'b0;
    else     audio_stb <= wrap && at_last;
  end

  // R8: every audio tick leaves the accumulator at its start value
  assert_acc_restart_R8: assert property (@(posedge clk) disable iff (rst)
    audio_stb |-> (acc == '0));
endmodule

// File: rtl/scan_frame_seq.sv
module scan_frame_seq #(
  parameter int CYC_W       = 16,
  parameter int LINE_W      = 9,
  parameter int AUDIO_LINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              std_sel,
  input  logic [CYC_W-1:0]  cycles_per_line,
  output logic              line_stb,
  output logic              vblank_stb,
  output logic              frame_irq,
  output logic              audio_stb,
  output logic [LINE_W-1:0] line_num
);
  logic wrap;

  sfs_line_div #(.CYC_W(CYC_W)) u_div (
    .clk(clk), .rst(rst), .cpl(cycles_per_line),
    .wrap(wrap), .line_stb(line_stb)
  );

  sfs_line_seq #(.LINE_W(LINE_W)) u_seq (
    .clk(clk), .rst(rst), .wrap(wrap), .std_sel(std_sel),
    .line_num(line_num), .vblank_stb(vblank_stb), .frame_irq(frame_irq)
  );

  sfs_audio_tick #(.AUDIO_LINES(AUDIO_LINES)) u_aud (
    .clk(clk), .rst(rst), .wrap(wrap), .audio_stb(audio_stb)
  );

  assert_stb_single_R2: assert property (@(posedge clk) disable iff (rst)
    line_stb |=> !line_stb);

  assert_vbl_on_line_R10: assert property (@(posedge clk) disable iff (rst)
    vblank_stb |-> line_stb);

  assert_irq_on_line_R10: assert property (@(posedge clk) disable iff (rst)
    frame_irq |-> line_stb);

  assert_aud_on_line_R10: assert property (@(posedge clk) disable iff (rst)
    audio_stb |-> line_stb);
endmodule

// File: tb/sim_scan_frame_seq.sv
`timescale 1ns/1ps
module sim_scan_frame_seq;
  localparam int CYC_W  = 16;
  localparam int LINE_W = 9;
  localparam int NVEC   = 12;

  // {std[31], strobe count[30:17], line[16:8], 5'b0, vbl[2], irq[1], aud[0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b0, 14'd1,     9'd1,   5'd0, 3'b000},
    {1'b0, 14'd32,    9'd32,  5'd0, 3'b001},
    {1'b0, 14'd240,   9'd240, 5'd0, 3'b100},
    {1'b0, 14'd262,   9'd262, 5'd0, 3'b000},
    {1'b0, 14'd263,   9'd0,   5'd0, 3'b010},
    {1'b0, 14'd503,   9'd240, 5'd0, 3'b100},
    {1'b0, 14'd8416,  9'd0,   5'd0, 3'b011},
    {1'b1, 14'd256,   9'd256, 5'd0, 3'b101},
    {1'b1, 14'd313,   9'd0,   5'd0, 3'b010},
    {1'b1, 14'd320,   9'd7,   5'd0, 3'b001},
    {1'b1, 14'd569,   9'd256, 5'd0, 3'b100},
    {1'b1, 14'd10016, 9'd0,   5'd0, 3'b011}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              std_sel = 1'b0;
  logic [CYC_W-1:0]  cycles_per_line = 16'd4;
  logic              line_stb, vblank_stb, frame_irq, audio_stb;
  logic [LINE_W-1:0] line_num;

  int nchk = 0, nbad = 0, nstb = 0, stray = 0;
  bit done = 0;

  scan_frame_seq #(.CYC_W(CYC_W), .LINE_W(LINE_W)) u0 (
    .clk(clk), .rst(rst), .std_sel(std_sel), .cycles_per_line(cycles_per_line),
    .line_stb(line_stb), .vblank_stb(vblank_stb), .frame_irq(frame_irq),
    .audio_stb(audio_stb), .line_num(line_num)
  );

  always #2 clk = ~clk;

  always @(negedge clk)
    if (!rst && !line_stb && (vblank_stb || frame_irq || audio_stb)) stray++;

  task automatic chk(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic s, input int cpl);
    rst = 1'b1;
    std_sel = s;
    cycles_per_line = CYC_W'(cpl);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nstb = 0;
  endtask

  task automatic next_strobe();
    do @(negedge clk); while (!line_stb);
    nstb++;
  endtask

  task automatic advance_to(input int n);
    while (nstb < n) next_strobe();
  endtask

  initial begin
    #800000;
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic prev_std;
    int   k;
    // R1: reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(line_num, 0, "R1 line_num");
    chk({line_stb, vblank_stb, frame_irq, audio_stb}, 0, "R1 strobes");

    // R2: first strobe after cycles_per_line edges, then a fixed period
    do_reset(1'b0, 7);
    k = 0;
    do begin @(negedge clk); k++; end while (!line_stb);
    chk(k, 7, "R2 first line");
    for (int j = 0; j < 3; j++) begin
      k = 0;
      do begin @(negedge clk); k++; end while (!line_stb);
      chk(k, 7, "R2 period");
    end

    // Vector table: R3..R8 at chosen strobe counts
    prev_std = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      logic s;
      int   n;
      s = VEC[i][31];
      n = int'(VEC[i][30:17]);
      if (i == 0 || s != prev_std || n <= nstb) do_reset(s, 4);
      prev_std = s;
      advance_to(n);
      chk(line_num, int'(VEC[i][16:8]), "R3/R4/R5 line_num");
      chk(vblank_stb, int'(VEC[i][2]), "R6 vblank_stb");
      chk(frame_irq, int'(VEC[i][1]), "R7 frame_irq");
      chk(audio_stb, int'(VEC[i][0]), "R8 audio_stb");
    end

    // R9: standard change mid-frame waits for the frame boundary
    do_reset(1'b0, 4);
    advance_to(100);
    std_sel = 1'b1;
    advance_to(240);
    chk(vblank_stb, 1, "R9 old standard vblank");
    advance_to(263);
    chk(frame_irq, 1, "R9 old frame length");
    advance_to(503);
    chk(vblank_stb, 0, "R9 no 60Hz vblank in new frame");
    advance_to(519);
    chk(vblank_stb, 1, "R9 new vblank line");
    advance_to(576);
    chk(frame_irq, 1, "R9 new frame length");

    // R10: no event strobe outside a line strobe
    chk(stray, 0, "R10 stray strobes");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule